// File: doc/BRIEF.md
# Interrupt Source Trigger-State Controller

This block holds the state of a small bank of interrupt sources. Each source has a priority, a type (message or level), a two-bit trigger state made of a presented bit P and a queued bit Q, a flag that marks it for a later retry, and a flag that records a hit taken while the source was masked. Trigger pulses and end-of-interrupt (EOI) commands arrive one source per cycle. The block turns them into delivery requests that carry a source number and a priority. A single presentation controller receives these requests and answers each one with accepted or refused.

Repeated message triggers merge into the Q bit, so at most one extra delivery stays queued behind the one in flight. A refused delivery is not dropped: the source is marked for retry. A retry scan, started on request, walks the sources from index 0 upward and presents again each source that is marked. A source whose priority is the masked value is never sent. It keeps a masked-pending mark instead, and it is presented once a real priority is written to it.

Top module: `irq_src_pq_ctl`

## Requirements
- R1: The trigger state uses P = bit 0 and Q = bit 1. A trigger on a message source sets the state to ((old << 1) & 3) | 1. A delivery request is raised only when the result is exactly 2'b01.
- R2: A message trigger that arrives while P is set leaves P set and sets Q. It raises no new request.
- R3: An EOI on a message source shifts the state right by one, so Q moves into P and Q clears. The source is presented again only if P is then set.
- R4: A trigger on a level source loads the trigger level value into P and presents the source when P goes from 0 to 1. An EOI on a level source leaves the state unchanged and presents the source again if P is set.
- R5: A source with priority 8'hFF is never sent to the presenter. Any presentation it would get, first delivery or retry, sets its masked-pending mark instead.
- R6: Writing a priority other than 8'hFF to a source that holds the masked-pending mark clears the mark and presents the source.
- R7: A refused delivery marks the source for retry. A retry scan presents only marked sources, one at a time, in ascending index order. A later scan does not present them again once they are accepted.
- R8: The retry mark is cleared at every presentation attempt, including an ordinary delivery of a marked source.
- R9: A request holds valid, source and priority steady until the presenter is ready. No new request is raised while a response is still owed.
- R10: Reset clears every trigger state, retry mark and masked-pending mark, sets every priority to 8'hFF, and leaves no request raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger pulse for one source |
| trig_src | input | 4 | Index of the triggered source |
| trig_level | input | 1 | Line level for a level source; ignored for a message source |
| eoi_valid | input | 1 | EOI command |
| eoi_src | input | 4 | Index of the source that receives the EOI |
| cfg_we | input | 1 | Write the priority and type of one source |
| cfg_src | input | 4 | Index of the source to configure |
| cfg_prio | input | 8 | Priority to write; 8'hFF means masked |
| cfg_level_type | input | 1 | 1 selects a level source, 0 a message source |
| scan_req | input | 1 | Start (or restart) a retry scan |
| req_valid | output | 1 | Delivery request valid |
| req_ready | input | 1 | Presenter takes the request |
| req_src | output | 4 | Source number of the request |
| req_prio | output | 8 | Priority of the request |
| rsp_valid | input | 1 | Presenter response strobe |
| rsp_accept | input | 1 | 1 means delivered, 0 means refused |

## Verification
The hardest situation to reach is a masked source that is marked for retry. To get there, a refusal has to set the retry mark, a masked priority has to be written afterwards, and a scan then has to reach that index. The bench builds this in order: it triggers the source, refuses it, masks it, scans, and sees that no request appears. It then unmasks the source and expects the delivery that the masked-pending mark was holding. The stall cases are reached by holding ready low and delaying the response while a second source becomes pending, so that the bench sees nothing leave early.

// File: rtl/irq_src_pq_pkg.sv
package irq_src_pq_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ISSUE = 2'd1,
    ENG_WAIT  = 2'd2
  } eng_state_t;

  // Trigger-state bit positions
  localparam int PQ_P = 0;
  localparam int PQ_Q = 1;

endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int W = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_src_pq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            trig_v_i,
  input  logic [IDX_W-1:0]                trig_src_i,
  input  logic                            trig_lvl_i,
  input  logic                            eoi_v_i,
  input  logic [IDX_W-1:0]                eoi_src_i,
  input  logic                            cfg_we_i,
  input  logic [IDX_W-1:0]                cfg_src_i,
  input  logic [PRIO_W-1:0]               cfg_prio_i,
  input  logic                            cfg_lvl_i,
  input  logic                            take_v_i,
  input  logic [IDX_W-1:0]                take_idx_i,
  input  logic                            refuse_v_i,
  input  logic [IDX_W-1:0]                refuse_idx_i,
  output logic [NUM_SRC-1:0]              pend_o,
  output logic [NUM_SRC-1:0]              resend_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o
);

  localparam logic [PRIO_W-1:0] MASKED = '1;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [1:0]        pq_q, pq_n, pq_e;
    logic              lvl_q, lvl_n;
    logic [PRIO_W-1:0] prio_q, prio_n;
    logic              rsnd_q, rsnd_n;
    logic              mpnd_q, mpnd_n;
    logic              pend_q, pend_n;
    logic              hit_t, hit_e, hit_c, hit_k, hit_r, present;

    assign hit_t = trig_v_i   && (trig_src_i   == IDX_W'(i));
    assign hit_e = eoi_v_i    && (eoi_src_i    == IDX_W'(i));
    assign hit_c = cfg_we_i   && (cfg_src_i    == IDX_W'(i));
    assign hit_k = take_v_i   && (take_idx_i   == IDX_W'(i));
    assign hit_r = refuse_v_i && (refuse_idx_i == IDX_W'(i));

    always_comb begin
      present = 1'b0;
      pq_e    = pq_q;
      // EOI first
      if (hit_e) begin
        if (!lvl_q) pq_e = pq_q >> 1;
        present = pq_e[PQ_P];
      end
      pq_n = pq_e;
      // then the trigger
      if (hit_t) begin
        if (lvl_q) begin
          present       = present | (trig_lvl_i & ~pq_e[PQ_P]);
          pq_n[PQ_P]    = trig_lvl_i;
        end else begin
          pq_n    = ((pq_e << 1) & 2'b11) | 2'b01;
          present = present | (pq_n == 2'b01);
        end
      end
      prio_n = prio_q;
      lvl_n  = lvl_q;
      mpnd_n = mpnd_q;
      if (hit_k && (prio_q == MASKED)) mpnd_n = 1'b1;
      if (hit_c) begin
        prio_n = cfg_prio_i;
        lvl_n  = cfg_lvl_i;
        if (mpnd_q && (cfg_prio_i != MASKED)) begin
          mpnd_n  = 1'b0;
          present = 1'b1;
        end
      end
      pend_n = (pend_q & ~hit_k) | present;
      rsnd_n = (rsnd_q & ~hit_k) | hit_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pq_q   <= '0;
        lvl_q  <= 1'b0;
        prio_q <= MASKED;
        rsnd_q <= 1'b0;
        mpnd_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        pq_q   <= pq_n;
        lvl_q  <= lvl_n;
        prio_q <= prio_n;
        rsnd_q <= rsnd_n;
        mpnd_q <= mpnd_n;
        pend_q <= pend_n;
      end
    end

    assign pend_o[i]   = pend_q;
    assign resend_o[i] = rsnd_q;
    assign prio_o[i]   = prio_q;

    AST_MSG_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_t && !hit_e && !lvl_q && pq_q[PQ_P]) |=> (pq_q == 2'b11)); // R2
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_k && !hit_r) |=> !rsnd_q); // R8
    AST_REFUSE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_r |=> rsnd_q); // R7
  end

endmodule

// File: rtl/irq_src_engine.sv
module irq_src_engine
  import irq_src_pq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              pend_i,
  input  logic [NUM_SRC-1:0]              resend_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_i,
  input  logic                            scan_req_i,
  output logic                            take_v_o,
  output logic [IDX_W-1:0]                take_idx_o,
  output logic                            refuse_v_o,
  output logic [IDX_W-1:0]                refuse_idx_o,
  output logic                            req_valid_o,
  input  logic                            req_ready_i,
  output logic [IDX_W-1:0]                req_src_o,
  output logic [PRIO_W-1:0]               req_prio_o,
  input  logic                            rsp_valid_i,
  input  logic                            rsp_accept_i
);

  localparam logic [PRIO_W-1:0] MASKED   = '1;
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_SRC - 1);

  eng_state_t        state_q, state_n;
  logic              scan_q, scan_n;
  logic [IDX_W-1:0]  ptr_q, ptr_n;
  logic [IDX_W-1:0]  cur_src_q, cur_src_n;
  logic [PRIO_W-1:0] cur_prio_q, cur_prio_n;
  logic              pend_any;
  logic [IDX_W-1:0]  pend_idx;

  irq_first_set #(.W(NUM_SRC)) u_pick (
    .vec_i (pend_i),
    .any_o (pend_any),
    .idx_o (pend_idx)
  );

  always_comb begin
    state_n    = state_q;
    scan_n     = scan_q;
    ptr_n      = ptr_q;
    cur_src_n  = cur_src_q;
    cur_prio_n = cur_prio_q;
    take_v_o   = 1'b0;
    take_idx_o = pend_idx;
    refuse_v_o = 1'b0;
    unique case (state_q)
      ENG_IDLE: begin
        if (pend_any) begin
          take_v_o = 1'b1;
        end else if (scan_q) begin
          ptr_n      = ptr_q + 1'b1;
          if (ptr_q == LAST_IDX) scan_n = 1'b0;
          take_idx_o = ptr_q;
          take_v_o   = resend_i[ptr_q];
        end
        if (take_v_o && (prio_i[take_idx_o] != MASKED)) begin
          cur_src_n  = take_idx_o;
          cur_prio_n = prio_i[take_idx_o];
          state_n    = ENG_ISSUE;
        end
      end
      ENG_ISSUE: if (req_ready_i) state_n = ENG_WAIT;
      ENG_WAIT: begin
        if (rsp_valid_i) begin
          refuse_v_o = !rsp_accept_i;
          state_n    = ENG_IDLE;
        end
      end
      default: state_n = ENG_IDLE;
    endcase
    if (scan_req_i) begin
      scan_n = 1'b1;
      ptr_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ENG_IDLE;
      scan_q     <= 1'b0;
      ptr_q      <= '0;
      cur_src_q  <= '0;
      cur_prio_q <= '0;
    end else begin
      state_q    <= state_n;
      scan_q     <= scan_n;
      ptr_q      <= ptr_n;
      cur_src_q  <= cur_src_n;
      cur_prio_q <= cur_prio_n;
    end
  end

  assign req_valid_o  = (state_q == ENG_ISSUE);
  assign req_src_o    = cur_src_q;
  assign req_prio_o   = cur_prio_q;
  assign refuse_idx_o = cur_src_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_src_o) && $stable(req_prio_o))); // R9
  AST_NO_MASKED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_prio_o != MASKED)); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> !req_valid_o); // R9

endmodule

// File: rtl/irq_src_pq_ctl.sv
module irq_src_pq_ctl #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [IDX_W-1:0]  trig_src,
  input  logic              trig_level,
  input  logic              eoi_valid,
  input  logic [IDX_W-1:0]  eoi_src,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_src,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_level_type,
  input  logic              scan_req,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IDX_W-1:0]  req_src,
  output logic [PRIO_W-1:0] req_prio,
  input  logic              rsp_valid,
  input  logic              rsp_accept
);

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic [NUM_SRC-1:0]             pend, resend;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic                           take_v, refuse_v;
  logic [IDX_W-1:0]               take_idx, refuse_idx;

  irq_src_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_bank (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .trig_v_i     (trig_valid),
    .trig_src_i   (trig_src),
    .trig_lvl_i   (trig_level),
    .eoi_v_i      (eoi_valid),
    .eoi_src_i    (eoi_src),
    .cfg_we_i     (cfg_we),
    .cfg_src_i    (cfg_src),
    .cfg_prio_i   (cfg_prio),
    .cfg_lvl_i    (cfg_level_type),
    .take_v_i     (take_v),
    .take_idx_i   (take_idx),
    .refuse_v_i   (refuse_v),
    .refuse_idx_i (refuse_idx),
    .pend_o       (pend),
    .resend_o     (resend),
    .prio_o       (prio)
  );

  irq_src_engine #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_eng (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .pend_i       (pend),
    .resend_i     (resend),
    .prio_i       (prio),
    .scan_req_i   (scan_req),
    .take_v_o     (take_v),
    .take_idx_o   (take_idx),
    .refuse_v_o   (refuse_v),
    .refuse_idx_o (refuse_idx),
    .req_valid_o  (req_valid),
    .req_ready_i  (req_ready),
    .req_src_o    (req_src),
    .req_prio_o   (req_prio),
    .rsp_valid_i  (rsp_valid),
    .rsp_accept_i (rsp_accept)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_s_n |-> !req_valid); // R10

endmodule

// File: tb/irq_src_pq_ctl_test.sv
module irq_src_pq_ctl_test;

  localparam int OP_CFG = 0, OP_TRIG = 1, OP_EOI = 2, OP_SCAN = 3;
  localparam int NV = 16;
  // {op[20:19], src[18:15], arg[14:6], exp[5], ok[4], tag[3:0]}
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 4'd2, 9'h005, 1'b0, 1'b1, 4'd1},  // R1 setup: s2 message, prio 5
    {2'd0, 4'd5, 9'h103, 1'b0, 1'b1, 4'd4},  // R4 setup: s5 level, prio 3
    {2'd1, 4'd2, 9'h000, 1'b1, 1'b1, 4'd1},  // R1 00 -> 01 presents
    {2'd1, 4'd2, 9'h000, 1'b0, 1'b1, 4'd2},  // R2 01 -> 11 silent
    {2'd1, 4'd2, 9'h000, 1'b0, 1'b1, 4'd2},  // R2 11 stays, silent
    {2'd2, 4'd2, 9'h000, 1'b1, 1'b1, 4'd3},  // R3 11 -> 01 presents
    {2'd2, 4'd2, 9'h000, 1'b0, 1'b1, 4'd3},  // R3 01 -> 00 silent
    {2'd1, 4'd2, 9'h000, 1'b1, 1'b1, 4'd1},  // R1 presents again
    {2'd2, 4'd2, 9'h000, 1'b0, 1'b1, 4'd3},  // R3 back to 00
    {2'd1, 4'd5, 9'h001, 1'b1, 1'b1, 4'd4},  // R4 level rises
    {2'd2, 4'd5, 9'h000, 1'b1, 1'b1, 4'd4},  // R4 EOI with P set re-presents
    {2'd1, 4'd5, 9'h000, 1'b0, 1'b1, 4'd4},  // R4 level falls
    {2'd2, 4'd5, 9'h000, 1'b0, 1'b1, 4'd4},  // R4 EOI with P clear silent
    {2'd1, 4'd9, 9'h000, 1'b0, 1'b1, 4'd5},  // R5 masked after reset
    {2'd0, 4'd9, 9'h007, 1'b1, 1'b1, 4'd6},  // R6 unmask replays
    {2'd0, 4'd9, 9'h0FF, 1'b0, 1'b1, 4'd5}   // R5 remask, no request
  };

  logic       clk, rst_n;
  logic       trig_valid, trig_level, eoi_valid, cfg_we, cfg_level_type, scan_req;
  logic [3:0] trig_src, eoi_src, cfg_src, req_src;
  logic [7:0] cfg_prio, req_prio;
  logic       req_valid, req_ready, rsp_valid, rsp_accept;
  int         n_tests, n_fails;
  logic [7:0] m_prio [16];

  irq_src_pq_ctl uut (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_src(trig_src), .trig_level(trig_level),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_prio(cfg_prio), .cfg_level_type(cfg_level_type),
    .scan_req(scan_req),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src), .req_prio(req_prio),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!cond) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_op(input int op, input logic [3:0] src, input logic [8:0] arg);
    @(negedge clk);
    case (op)
      OP_CFG:  begin cfg_we = 1'b1; cfg_src = src; cfg_prio = arg[7:0]; cfg_level_type = arg[8];
                     m_prio[src] = arg[7:0]; end
      OP_TRIG: begin trig_valid = 1'b1; trig_src = src; trig_level = arg[0]; end
      OP_EOI:  begin eoi_valid = 1'b1; eoi_src = src; end
      default: scan_req = 1'b1;
    endcase
    @(negedge clk);
    cfg_we = 1'b0; trig_valid = 1'b0; eoi_valid = 1'b0; scan_req = 1'b0;
  endtask

  task automatic respond(input bit ok);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_accept = ok;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic expect_req(input bit exp, input logic [3:0] esrc, input bit ok,
                            input int win, input string tag);
    bit got;
    logic [3:0] s;
    logic [7:0] p;
    got = 1'b0;
    for (int c = 0; c < win; c++) begin
      if (req_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    s = req_src; p = req_prio;
    check(got == exp, {tag, " request raised"}, 32'(got), 32'(exp));
    if (got && exp) begin
      check(s == esrc, {tag, " source"}, 32'(s), 32'(esrc));
      check(p == m_prio[esrc], {tag, " priority"}, 32'(p), 32'(m_prio[esrc]));
    end
    if (got) respond(ok);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(req_valid == 1'b0, "R10 no request in reset", 32'(req_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) m_prio[i] = 8'hFF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

  initial begin
    n_tests = 0; n_fails = 0;
    trig_valid = 0; trig_level = 0; eoi_valid = 0; cfg_we = 0; cfg_level_type = 0;
    scan_req = 0; trig_src = 0; eoi_src = 0; cfg_src = 0; cfg_prio = 0;
    req_ready = 1; rsp_valid = 0; rsp_accept = 0;
    do_reset();
    check(req_valid == 1'b0, "R10 idle after reset", 32'(req_valid), 32'd0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      automatic logic [20:0] e = VEC[v];
      automatic string tag = $sformatf("R%0d row %0d", e[3:0], v);
      drive_op(int'(e[20:19]), e[18:15], e[14:6]);
      expect_req(e[5], e[18:15], e[4], 8, tag);
    end

    // R9: request held while not ready, nothing new while a response is owed
    req_ready = 1'b0;
    drive_op(OP_TRIG, 4'd2, 9'h0);
    for (int c = 0; c < 8 && !req_valid; c++) @(negedge clk);
    check(req_valid && req_src == 4'd2, "R9 request raised", 32'(req_src), 32'd2);
    drive_op(OP_TRIG, 4'd5, 9'h001);
    for (int c = 0; c < 3; c++) begin
      check(req_valid && req_src == 4'd2 && req_prio == 8'd5, "R9 held while not ready",
            32'({req_valid, req_src}), 32'({1'b1, 4'd2}));
      @(negedge clk);
    end
    req_ready = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      check(req_valid == 1'b0, "R9 silent until response", 32'(req_valid), 32'd0);
      @(negedge clk);
    end
    respond(1'b1);
    expect_req(1'b1, 4'd5, 1'b1, 8, "R9 queued level source next");

    // R7: refusals retried by scan in ascending order, then cleared
    drive_op(OP_CFG, 4'd1, 9'h004);
    drive_op(OP_CFG, 4'd7, 9'h006);
    drive_op(OP_TRIG, 4'd7, 9'h0);
    expect_req(1'b1, 4'd7, 1'b0, 8, "R7 first s7 refused");
    drive_op(OP_TRIG, 4'd1, 9'h0);
    expect_req(1'b1, 4'd1, 1'b0, 8, "R7 first s1 refused");
    drive_op(OP_SCAN, 4'd0, 9'h0);
    expect_req(1'b1, 4'd1, 1'b1, 40, "R7 scan lower index first");
    expect_req(1'b1, 4'd7, 1'b1, 40, "R7 scan next index");
    drive_op(OP_SCAN, 4'd0, 9'h0);
    expect_req(1'b0, 4'd0, 1'b1, 30, "R7 second scan empty");

    // R8: ordinary delivery of a marked source clears its mark
    drive_op(OP_EOI, 4'd5, 9'h0);
    expect_req(1'b1, 4'd5, 1'b0, 8, "R8 level re-present refused");
    drive_op(OP_EOI, 4'd5, 9'h0);
    expect_req(1'b1, 4'd5, 1'b1, 8, "R8 level re-present accepted");
    drive_op(OP_SCAN, 4'd0, 9'h0);
    expect_req(1'b0, 4'd0, 1'b1, 30, "R8 mark gone after delivery");

    // R5 / R6: a marked source masked before the scan is held, then replayed
    drive_op(OP_EOI, 4'd7, 9'h0);
    expect_req(1'b0, 4'd0, 1'b1, 6, "R3 s7 EOI to idle");
    drive_op(OP_TRIG, 4'd7, 9'h0);
    expect_req(1'b1, 4'd7, 1'b0, 8, "R7 s7 refused again");
    drive_op(OP_CFG, 4'd7, 9'h0FF);
    expect_req(1'b0, 4'd0, 1'b1, 6, "R5 mask write silent");
    drive_op(OP_SCAN, 4'd0, 9'h0);
    expect_req(1'b0, 4'd0, 1'b1, 30, "R5 masked retry not sent");
    drive_op(OP_CFG, 4'd7, 9'h006);
    expect_req(1'b1, 4'd7, 1'b1, 8, "R6 unmask replays retry");

    // R10: reset mid-run restores masked priorities and clears state
    do_reset();
    drive_op(OP_TRIG, 4'd2, 9'h0);
    expect_req(1'b0, 4'd0, 1'b1, 8, "R10 priority masked after reset");
    drive_op(OP_SCAN, 4'd0, 9'h0);
    expect_req(1'b0, 4'd0, 1'b1, 30, "R10 no retry marks after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

endmodule